// File: doc/BRIEF.md
# Narrow-Access Burst Adapter

This block connects a processor-side port that makes single loads and stores of 1, 2, 4 or 8 bytes to a 64-bit burst memory interface. Every transfer on that interface is a burst of eight 64-bit beats. For each request the adapter issues exactly one burst command. The whole aligned 64-byte line moves over the bus, even for a single byte.

On a read, all eight beats are consumed. The addressed beat is kept, and the requested bytes go back right-justified and zero-extended. On a write, all eight beats carry the full 64 data bits. A per-byte mask tells the memory which bytes to store, so only the addressed bytes change. No earlier read data is reused.

Only one request is in flight at a time. A request that is not naturally aligned is refused with an error pulse and never reaches the memory.

Top module: `narrow_burst_adapter`

## Requirements
- R1: Each aligned request produces exactly one command on the memory side. The command carries the direction (`mem_cmd_write` = 1 for a store) and the request address with its low six bits cleared. The command stays valid and unchanged until `mem_cmd_ready` is seen.
- R2: `req_ready` is high while the adapter is idle. It goes low on the cycle after an aligned request is accepted and stays low until the last of the eight beats has been transferred.
- R3: A read returns the requested bytes in `rsp_rdata`. Address bits [5:3] select the beat and address bits [2:0] select the first byte lane within it, where lane k is data bits [8k+7:8k]. The bytes are right-justified and every bit above them is zero. `rsp_valid` is a single-cycle pulse on the cycle after the eighth read beat is taken.
- R4: Every read consumes all eight beats (`mem_rd_valid` strobes), whatever the request size. No response appears before the eighth beat has been taken.
- R5: Nothing is cached. Repeating a read to the same address issues a new burst and returns the data of that new burst.
- R6: A write sends exactly eight beats, each advanced by `mem_wr_valid` && `mem_wr_ready`. On every beat the data word holds the low request bytes shifted up to byte lane addr[2:0], and all other bytes are zero.
- R7: Mask bit i = 1 means byte lane i is not stored. On every beat except the one selected by addr[5:3], all mask bits are 1. On the selected beat, the mask bits are 0 exactly for the written lanes.
- R8: A request whose address is not a multiple of its size is refused. `rsp_err` pulses for one cycle on the cycle after acceptance, no memory command is issued, and `req_ready` stays high.
- R9: The size code `req_size` selects 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R10: After reset, `req_ready` is 1 and `rsp_valid`, `rsp_err`, `mem_cmd_valid` and `mem_wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code (R9) |
| req_wdata | input | 64 | Store data, right-justified |
| rsp_valid | output | 1 | Load data valid pulse |
| rsp_err | output | 1 | Misaligned request pulse |
| rsp_rdata | output | 64 | Load data, zero-extended |
| mem_cmd_valid | output | 1 | Burst command valid |
| mem_cmd_ready | input | 1 | Memory takes command |
| mem_cmd_write | output | 1 | Burst direction |
| mem_cmd_addr | output | ADDR_W | Line-aligned burst address |
| mem_rd_valid | input | 1 | Read beat strobe |
| mem_rd_data | input | 64 | Read beat data |
| mem_wr_valid | output | 1 | Write beat valid |
| mem_wr_ready | input | 1 | Memory takes write beat |
| mem_wr_data | output | 64 | Write beat data |
| mem_wr_mask | output | 8 | Per-byte store inhibit |

## Verification
The hardest cases to reach from the ports are those where the wanted beat is not the last one, and where the beats and handshakes arrive with gaps. In those cases the adapter must hold the captured beat while unrelated beats stream past. The memory model in the bench inserts idle cycles between read beats and toggles write-ready irregularly. The requests target beats 0, 1, 3, 4, 5, 7 and lane 7, so that capture, hold and final extraction are each exercised under stall. Each read burst carries a generation-specific pattern, so a repeated address returning stale data would show up as a mismatch.

// File: rtl/narrow_adapter_pkg.sv
package narrow_adapter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } adp_state_e;

  localparam logic [1:0] SZ_ONE_BYTE = 2'd0;
endpackage

// File: rtl/narrow_req_decode.sv
module narrow_req_decode #(
  parameter int BYTES = 8,
  parameter int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0]   off,
  input  logic [1:0]         size,
  input  logic [8*BYTES-1:0] wdata,
  output logic               aligned,
  output logic [BYTES-1:0]   byte_en,
  output logic [8*BYTES-1:0] size_mask,
  output logic [8*BYTES-1:0] wdata_lane
);
  logic [BYTES-1:0] size_lane;
  logic [OFF_W-1:0] low_mask;
  logic [OFF_W+2:0] bit_shift;

  // lane i belongs to the access when i < 2**size
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign size_lane[i]          = (32'(i) < (32'd1 << size));
    assign size_mask[8*i +: 8]   = {8{size_lane[i]}};
  end

  always_comb begin
    low_mask   = OFF_W'((32'd1 << size) - 32'd1);
    aligned    = (off & low_mask) == '0;
    byte_en    = size_lane << off;
    bit_shift  = {off, 3'b000};
    wdata_lane = (wdata & size_mask) << bit_shift;
  end
endmodule

// File: rtl/narrow_rd_extract.sv
module narrow_rd_extract #(
  parameter int BYTES = 8,
  parameter int OFF_W = $clog2(BYTES)
) (
  input  logic [8*BYTES-1:0] beat,
  input  logic [OFF_W-1:0]   off,
  input  logic [8*BYTES-1:0] size_mask,
  output logic [8*BYTES-1:0] rdata
);
  logic [OFF_W+2:0] bit_shift;

  always_comb begin
    bit_shift = {off, 3'b000};
    rdata     = (beat >> bit_shift) & size_mask;
  end
endmodule

// File: rtl/narrow_burst_adapter.sv
module narrow_burst_adapter
  import narrow_adapter_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 8,
  parameter int BEATS  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [8*BYTES-1:0]  req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [8*BYTES-1:0]  rsp_rdata,
  output logic                mem_cmd_valid,
  input  logic                mem_cmd_ready,
  output logic                mem_cmd_write,
  output logic [ADDR_W-1:0]   mem_cmd_addr,
  input  logic                mem_rd_valid,
  input  logic [8*BYTES-1:0]  mem_rd_data,
  output logic                mem_wr_valid,
  input  logic                mem_wr_ready,
  output logic [8*BYTES-1:0]  mem_wr_data,
  output logic [BYTES-1:0]    mem_wr_mask
);
  localparam int DATA_W = 8 * BYTES;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int LINE_W = OFF_W + BEAT_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  adp_state_e         state;
  logic [BEAT_W-1:0]  cnt;
  logic [BEAT_W-1:0]  lat_sel;
  logic [OFF_W-1:0]   lat_off;
  logic [1:0]         lat_size;
  logic [DATA_W-1:0]  lat_mask;
  logic [BYTES-1:0]   lat_byte_en;
  logic [DATA_W-1:0]  lat_wdata;
  logic [DATA_W-1:0]  cap_q;

  logic               dec_aligned;
  logic [BYTES-1:0]   dec_byte_en;
  logic [DATA_W-1:0]  dec_size_mask;
  logic [DATA_W-1:0]  dec_wdata_lane;
  logic [DATA_W-1:0]  beat_now;
  logic [DATA_W-1:0]  ext_rdata;
  logic               on_sel;

  narrow_req_decode #(.BYTES(BYTES), .OFF_W(OFF_W)) u_decode (
    .off       (req_addr[OFF_W-1:0]),
    .size      (req_size),
    .wdata     (req_wdata),
    .aligned   (dec_aligned),
    .byte_en   (dec_byte_en),
    .size_mask (dec_size_mask),
    .wdata_lane(dec_wdata_lane)
  );

  // the addressed beat may be the one arriving right now
  assign on_sel   = (cnt == lat_sel);
  assign beat_now = on_sel ? mem_rd_data : cap_q;

  narrow_rd_extract #(.BYTES(BYTES), .OFF_W(OFF_W)) u_extract (
    .beat      (beat_now),
    .off       (lat_off),
    .size_mask (lat_mask),
    .rdata     (ext_rdata)
  );

  assign mem_wr_valid = (state == ST_WR);
  assign mem_wr_data  = lat_wdata;
  assign mem_wr_mask  = on_sel ? ~lat_byte_en : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      req_ready     <= 1'b1;
      rsp_valid     <= 1'b0;
      rsp_err       <= 1'b0;
      rsp_rdata     <= '0;
      mem_cmd_valid <= 1'b0;
      mem_cmd_write <= 1'b0;
      mem_cmd_addr  <= '0;
      cnt           <= '0;
      lat_sel       <= '0;
      lat_off       <= '0;
      lat_size      <= '0;
      lat_mask      <= '0;
      lat_byte_en   <= '0;
      lat_wdata     <= '0;
      cap_q         <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            if (!dec_aligned) begin
              rsp_err <= 1'b1;
            end else begin
              state         <= ST_CMD;
              req_ready     <= 1'b0;
              mem_cmd_valid <= 1'b1;
              mem_cmd_write <= req_write;
              mem_cmd_addr  <= {req_addr[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};
              lat_sel       <= req_addr[LINE_W-1:OFF_W];
              lat_off       <= req_addr[OFF_W-1:0];
              lat_size      <= req_size;
              lat_mask      <= dec_size_mask;
              lat_byte_en   <= dec_byte_en;
              lat_wdata     <= dec_wdata_lane;
            end
          end
        end
        ST_CMD: begin
          if (mem_cmd_ready) begin
            mem_cmd_valid <= 1'b0;
            cnt           <= '0;
            state         <= mem_cmd_write ? ST_WR : ST_RD;
          end
        end
        ST_RD: begin
          if (mem_rd_valid) begin
            if (on_sel) cap_q <= mem_rd_data;
            cnt <= cnt + BEAT_W'(1);
            if (cnt == LAST_BEAT) begin
              state     <= ST_IDLE;
              req_ready <= 1'b1;
              rsp_valid <= 1'b1;
              rsp_rdata <= ext_rdata;
            end
          end
        end
        ST_WR: begin
          if (mem_wr_ready) begin
            cnt <= cnt + BEAT_W'(1);
            if (cnt == LAST_BEAT) begin
              state     <= ST_IDLE;
              req_ready <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !req_ready); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_cmd_valid && !mem_wr_valid)); // R2
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd_valid && !mem_cmd_ready) |=> (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write))); // R1
  AST_CMD_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_cmd_valid |-> (mem_cmd_addr[LINE_W-1:0] == '0)); // R1
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R3
  AST_RSP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(mem_rd_valid) && $past(state == ST_RD))); // R4
  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && lat_size == SZ_ONE_BYTE) |-> (rsp_rdata[DATA_W-1:8] == '0)); // R3
  AST_OFF_BEAT_MASKED: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> ((&mem_wr_mask) || (cnt == lat_sel))); // R7
  AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (!mem_cmd_valid && req_ready)); // R8
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_cmd_valid, mem_wr_valid, rsp_valid})); // R2
endmodule

// File: tb/narrow_burst_adapter_bench.sv
module narrow_burst_adapter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic        mem_cmd_valid;
  logic        mem_cmd_ready = 1'b0;
  logic        mem_cmd_write;
  logic [31:0] mem_cmd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [63:0] mem_wr_data;
  logic [7:0]  mem_wr_mask;

  always #10 clk = ~clk;

  narrow_burst_adapter u_narrow_burst_adapter (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask)
  );

  int n_chk = 0;
  int n_bad = 0;
  int drv_rgen = 0;
  int rd_beats = 0;
  bit done = 1'b0;

  logic [32:0] exp_cmd_q[$];
  logic [63:0] exp_rsp_q[$];
  logic [63:0] exp_wdata_q[$];
  logic [7:0]  exp_wmask_q[$];
  logic [2:0]  exp_wsel_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int g, input int b);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = 8'(g * 64 + b * 8 + i) ^ 8'(g * 37);
    return v;
  endfunction

  function automatic logic [63:0] szmask(input logic [1:0] sz);
    return (sz == 2'd3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  // driver: issues one request and records what must follow
  task automatic do_req(input logic w, input logic [31:0] a, input logic [1:0] sz,
                        input logic [63:0] wd);
    bit al;
    int lane;
    int sel;
    lane = int'(a[2:0]);
    sel  = int'(a[5:3]);
    al   = ((a[2:0] & 3'((32'd1 << sz) - 1)) == 3'd0);
    while (!req_ready) @(negedge clk);
    if (al) begin
      exp_cmd_q.push_back({w, a[31:6], 6'd0});
      if (!w) begin
        exp_rsp_q.push_back((pat(drv_rgen, sel) >> (8 * lane)) & szmask(sz));
        drv_rgen++;
      end else begin
        exp_wdata_q.push_back((wd & szmask(sz)) << (8 * lane));
        exp_wmask_q.push_back(~(8'((9'd1 << (1 << sz)) - 9'd1) << lane));
        exp_wsel_q.push_back(3'(sel));
      end
    end
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (!al) begin
      chk("R8 rsp_err pulse", 64'(rsp_err), 64'd1);
      chk("R8 ready stays high", 64'(req_ready), 64'd1);
      chk("R8 no command", 64'(mem_cmd_valid), 64'd0);
      @(negedge clk);
      chk("R8 rsp_err one cycle", 64'(rsp_err), 64'd0);
    end else begin
      chk("R2 ready low after accept", 64'(req_ready), 64'd0);
      while (!req_ready) @(negedge clk);
    end
  endtask

  // memory model / responder
  initial begin
    logic [32:0] got;
    logic [32:0] want;
    logic [63:0] wexp;
    logic [7:0]  wmexp;
    logic [2:0]  wsel;
    int rgen;
    int bw;
    int k;
    rgen = 0;
    forever begin
      @(negedge clk);
      if (mem_cmd_valid) begin
        @(negedge clk);
        chk("R1 command held", 64'(mem_cmd_valid), 64'd1);
        got = {mem_cmd_write, mem_cmd_addr};
        mem_cmd_ready = 1'b1;
        if (exp_cmd_q.size() == 0) begin
          chk("R8 unexpected command", 64'(got), 64'h1_FFFF_FFFF);
          want = got;
        end else begin
          want = exp_cmd_q.pop_front();
        end
        chk("R1 command dir/addr", 64'(got), 64'(want));
        @(negedge clk);
        mem_cmd_ready = 1'b0;
        rd_beats = 0;
        if (!got[32]) begin
          for (int b = 0; b < 8; b++) begin
            if (b % 3 == 2) begin
              mem_rd_valid = 1'b0;
              @(negedge clk);
            end
            mem_rd_valid = 1'b1;
            mem_rd_data  = pat(rgen, b);
            rd_beats     = b + 1;
            @(negedge clk);
          end
          mem_rd_valid = 1'b0;
          chk("R3 rsp one cycle after last beat", 64'(rsp_valid), 64'd1);
          rgen++;
        end else begin
          wexp  = exp_wdata_q.size() ? exp_wdata_q.pop_front() : '0;
          wmexp = exp_wmask_q.size() ? exp_wmask_q.pop_front() : '0;
          wsel  = exp_wsel_q.size() ? exp_wsel_q.pop_front() : '0;
          bw = 0;
          k  = 0;
          while (bw < 8) begin
            mem_wr_ready = (k % 3 != 1);
            if (mem_wr_ready && mem_wr_valid) begin
              chk("R6 write beat data", mem_wr_data, wexp);
              chk("R7 write beat mask", 64'(mem_wr_mask),
                  64'((bw == int'(wsel)) ? wmexp : 8'hFF));
              bw++;
            end
            k++;
            @(negedge clk);
          end
          mem_wr_ready = 1'b0;
          chk("R6 exactly eight beats", 64'(mem_wr_valid), 64'd0);
        end
      end
    end
  end

  // monitor / scoreboard for read responses
  initial begin
    bit prev;
    logic [63:0] e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (rsp_valid) begin
          if (prev) chk("R3 rsp_valid single pulse", 64'd1, 64'd0);
          e = exp_rsp_q.size() ? exp_rsp_q.pop_front() : ~rsp_rdata;
          chk("R3 R9 R5 read data", rsp_rdata, e);
          chk("R4 all eight beats before response", 64'(rd_beats), 64'd8);
        end
        prev = rsp_valid;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ready in reset", 64'(req_ready), 64'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready after reset", 64'(req_ready), 64'd1);
    chk("R10 quiet after reset",
        64'({rsp_valid, rsp_err, mem_cmd_valid, mem_wr_valid}), 64'd0);

    // reads of every size, various beats and lanes (R3 R4 R9)
    do_req(1'b0, 32'h0000_1005, 2'd0, '0);
    do_req(1'b0, 32'h0000_201E, 2'd1, '0);
    do_req(1'b0, 32'h0000_003C, 2'd2, '0);
    do_req(1'b0, 32'h0000_0100, 2'd3, '0);
    do_req(1'b0, 32'h0000_007F, 2'd0, '0);
    do_req(1'b0, 32'h0000_0128, 2'd3, '0);
    // no caching: same address again (R5)
    do_req(1'b0, 32'h0000_0100, 2'd3, '0);
    do_req(1'b0, 32'h0000_0100, 2'd3, '0);
    // writes (R6 R7)
    do_req(1'b1, 32'h0000_0023, 2'd0, 64'hFFEE_DDCC_BBAA_9977);
    do_req(1'b1, 32'h0000_4012, 2'd1, 64'h1234_5678_9ABC_DEF0);
    do_req(1'b1, 32'h0000_0008, 2'd2, 64'hCAFE_F00D_8765_4321);
    do_req(1'b1, 32'h0000_0038, 2'd3, 64'h0123_4567_89AB_CDEF);
    do_req(1'b1, 32'h0000_003F, 2'd0, 64'h0000_0000_0000_005A);
    // misaligned (R8)
    do_req(1'b0, 32'h0000_0003, 2'd1, '0);
    do_req(1'b0, 32'h0000_0006, 2'd2, '0);
    do_req(1'b0, 32'h0000_0044, 2'd3, '0);
    do_req(1'b1, 32'h0000_0011, 2'd1, 64'hDEAD);
    // aligned access right after refusals still works
    do_req(1'b0, 32'h0000_0044, 2'd2, '0);

    repeat (30) @(negedge clk);
    chk("R1 R8 commands outstanding", 64'(exp_cmd_q.size()), 64'd0);
    chk("R3 responses outstanding", 64'(exp_rsp_q.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule